// File: doc/BRIEF.md
# Register-Mapped GPIO and Interrupt Expander

The block hangs off a simple parallel host bus and gives the host a few banks of general-purpose pins and one interrupt register. Each bank register returns, bit by bit, the value held in the output latch for pins configured as outputs, and the synchronised live level for pins configured as inputs. A write to a bank replaces its latch contents. The pin directions and the latch power-on value are fixed by parameters.

The low pins of the device are also interrupt sources. Each one passes through a two-flop synchroniser, and a rising edge on it sets a pending bit. The host reads the pending bits from the status register and clears them by writing the acknowledge pattern to that same register. The pattern is all ones or all zeros, chosen by a parameter. The block has no mask register, so any pending bit drives the single summary interrupt line high. The host treats that line as edge-sensitive. For this reason an acknowledge always pulls the line low for at least one cycle, and any event that is still pending afterwards produces a fresh rising edge.

Registers sit at byte addresses equal to the register index shifted left by the bus lane shift. The shift is 1 on a 16-bit bus and 2 on a 32-bit bus. Both the bus width and the register width (8 or 16 bits) are parameters.

Top module: `gpx_expander`

## Requirements
- R1: The register index is the byte address shifted right by 1 when BUS_W is 16, or by 2 when BUS_W is 32. An address with any of the shifted-out bits set, or with an index above N_BANKS, selects nothing: a write to it changes no state, and a read of it returns zero.
- R2: Indices 0 to N_BANKS-1 are the GPIO banks. Pin g lives in bank g / REG_W at bit g % REG_W. Index N_BANKS is the interrupt status register. Only write-data bits REG_W-1:0 are used.
- R3: A bank read returns the latch bit for each pin whose DIR_MASK bit is 1, and the synchronised input level for each pin whose DIR_MASK bit is 0. Read-data bits above REG_W are zero.
- R4: A bank write loads its REG_W latch bits, and pin_out shows them. pin_oe always equals DIR_MASK.
- R5: On reset the latch holds OUT_INIT, no bit is pending, irq_out is low, and host_rdata and host_rvalid are zero.
- R6: A strobe sampled at clock edge k takes effect at edge k+1. At that edge a write updates state, and a read loads host_rdata with host_rvalid high for one cycle.
- R7: A rising edge on pin i, where i < N_IRQ, sets pending bit i at the third clock edge after the pin changes. A falling edge sets nothing. The status register reads the pending bits in bits N_IRQ-1:0.
- R8: A status-register write whose low REG_W bits equal the acknowledge pattern clears every pending bit. The pattern is all ones when ACK_ONES is 1 and all zeros when it is 0. A write of any other value has no effect.
- R9: A source edge that arrives at the same edge as an acknowledge leaves its pending bit set.
- R10: No mask exists. irq_out is high exactly when some bit is pending, except in the cycle that follows an acknowledge. It rises at the same edge that sets the first pending bit.
- R11: After an acknowledge, irq_out is low for at least one cycle. It then rises again if any bit is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Byte address of the access |
| host_wdata | input | BUS_W | Write data |
| host_we | input | 1 | Write strobe, one cycle |
| host_re | input | 1 | Read strobe, one cycle |
| host_rdata | output | BUS_W | Read data, held until the next read |
| host_rvalid | output | 1 | High for the cycle in which the read data is new |
| pin_in | input | N_BANKS*REG_W | External pin levels, asynchronous |
| pin_out | output | N_BANKS*REG_W | Output latch contents |
| pin_oe | output | N_BANKS*REG_W | Output enable per pin (DIR_MASK) |
| irq_out | output | 1 | Summary interrupt, level high while events are pending |

## Verification
Each result has a fixed delay after its stimulus. Strobes are driven on a falling edge, so they are captured at the next rising edge. A write then becomes visible on pin_out, and read data on host_rdata, one rising edge after that. A pin change reaches the pending bits and irq_out on the third rising edge. The bench samples on a falling edge after exactly that many rising edges, and checks irq_out one edge early to confirm it is still low. An acknowledge is placed so that it lands on the same edge as a new source edge. This checks that the line drops for one cycle and then rises again, and that the new bit survives the acknowledge.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int GPX_ADDR_MAX = 16;
    localparam int GPX_DATA_MAX = 32;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_BANK,
        TGT_STATUS
    } tgt_e;

    typedef struct packed {
        logic                     wr;
        logic                     rd;
        logic [GPX_ADDR_MAX-1:0]  addr;
        logic [GPX_DATA_MAX-1:0]  wdata;
    } host_req_t;

    typedef struct packed {
        tgt_e       tgt;
        logic [7:0] index;
    } decode_t;

    function automatic int lane_shift(input int bus_w);
        return (bus_w == 32) ? 2 : 1;
    endfunction

    function automatic decode_t decode_addr(input logic [GPX_ADDR_MAX-1:0] addr,
                                            input int bus_w,
                                            input int n_banks);
        decode_t                 d;
        int                      sh;
        logic [GPX_ADDR_MAX-1:0] low_mask;
        logic [GPX_ADDR_MAX-1:0] idx;
        sh       = lane_shift(bus_w);
        low_mask = (GPX_ADDR_MAX'(1) << sh) - GPX_ADDR_MAX'(1);
        idx      = addr >> sh;
        d.tgt    = TGT_NONE;
        d.index  = '0;
        if ((addr & low_mask) == '0) begin
            if (idx < GPX_ADDR_MAX'(n_banks)) begin
                d.tgt   = TGT_BANK;
                d.index = idx[7:0];
            end else if (idx == GPX_ADDR_MAX'(n_banks)) begin
                d.tgt = TGT_STATUS;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;

endmodule

// File: rtl/gpx_irq.sv
module gpx_irq #(
    parameter int N_IRQ    = 8,
    parameter int REG_W    = 8,
    parameter bit ACK_ONES = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] src_sync,
    input  logic             status_wr,
    input  logic [REG_W-1:0] status_wdata,
    output logic [N_IRQ-1:0] pending,
    output logic             irq_out
);

    localparam logic [REG_W-1:0] ACK_PAT = {REG_W{ACK_ONES}};

    logic [N_IRQ-1:0] prev_q;
    logic [N_IRQ-1:0] rise;
    logic [N_IRQ-1:0] pend_q;
    logic [N_IRQ-1:0] pend_next;
    logic             ack_hit;
    logic             irq_q;

    assign rise    = src_sync & ~prev_q;
    assign ack_hit = status_wr && (status_wdata == ACK_PAT);

    always_comb begin
        if (ack_hit) pend_next = rise;
        else         pend_next = pend_q | rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            prev_q <= src_sync;
            pend_q <= pend_next;
            irq_q  <= !ack_hit && (|pend_next);
        end
    end

    assign pending = pend_q;
    assign irq_out = irq_q;

    // R11: the line is low in the cycle after an acknowledge
    a_r11_ack_drop: assert property (@(posedge clk) disable iff (rst)
        ack_hit |=> !irq_out);

    // R9: an edge coinciding with the acknowledge stays pending
    a_r9_keep_edge: assert property (@(posedge clk) disable iff (rst)
        ack_hit |=> ((pending & $past(rise)) == $past(rise)));

    // R10: pending work without an acknowledge keeps the line high
    a_r10_irq_follows: assert property (@(posedge clk) disable iff (rst)
        ((|pending) && !ack_hit) |=> irq_out);

    // R10: the line is never high without a pending bit
    a_r10_irq_needs_pending: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (|pending));

endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int BUS_W   = 16,
    parameter int REG_W   = 8,
    parameter int N_BANKS = 2,
    parameter int N_IRQ   = 8,
    parameter logic [N_BANKS*REG_W-1:0] DIR_MASK = '1,
    parameter logic [N_BANKS*REG_W-1:0] OUT_INIT = '0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  host_req_t                req,
    input  logic [N_BANKS*REG_W-1:0] pins_sync,
    input  logic [N_IRQ-1:0]         pending,
    output logic [N_BANKS*REG_W-1:0] latch,
    output logic [BUS_W-1:0]         rdata,
    output logic                     rvalid,
    output logic                     status_wr,
    output logic [REG_W-1:0]         status_wdata
);

    localparam int NPINS = N_BANKS * REG_W;

    decode_t          dec;
    logic [NPINS-1:0] latch_q;
    logic [NPINS-1:0] view;
    logic [BUS_W-1:0] rd_next;
    logic [BUS_W-1:0] rdata_q;
    logic             rvalid_q;
    logic             bank_wr;

    assign dec          = decode_addr(req.addr, BUS_W, N_BANKS);
    assign bank_wr      = req.wr && (dec.tgt == TGT_BANK);
    assign status_wr    = req.wr && (dec.tgt == TGT_STATUS);
    assign status_wdata = req.wdata[REG_W-1:0];
    assign view         = (latch_q & DIR_MASK) | (pins_sync & ~DIR_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= OUT_INIT;
        end else begin
            for (int b = 0; b < N_BANKS; b++) begin
                if (bank_wr && (dec.index == 8'(b)))
                    latch_q[b*REG_W +: REG_W] <= req.wdata[REG_W-1:0];
            end
        end
    end

    always_comb begin
        rd_next = '0;
        case (dec.tgt)
            TGT_BANK: begin
                for (int b = 0; b < N_BANKS; b++) begin
                    if (dec.index == 8'(b))
                        rd_next[REG_W-1:0] = view[b*REG_W +: REG_W];
                end
            end
            TGT_STATUS: rd_next[N_IRQ-1:0] = pending;
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= req.rd;
            if (req.rd) rdata_q <= rd_next;
        end
    end

    assign latch  = latch_q;
    assign rdata  = rdata_q;
    assign rvalid = rvalid_q;

    // R1: a write that decodes to nothing leaves every latch bit alone
    a_r1_bad_addr_no_write: assert property (@(posedge clk) disable iff (rst)
        (req.wr && (dec.tgt == TGT_NONE)) |=> $stable(latch));

    // R6: a read strobe yields valid data one edge later
    a_r6_read_latency: assert property (@(posedge clk) disable iff (rst)
        req.rd |=> rvalid);

    // R1: a read of an unmapped address returns zero
    a_r1_bad_addr_zero: assert property (@(posedge clk) disable iff (rst)
        (req.rd && (dec.tgt == TGT_NONE)) |=> (rdata == '0));

endmodule

// File: rtl/gpx_expander.sv
module gpx_expander
    import gpx_pkg::*;
#(
    parameter int BUS_W    = 16,
    parameter int REG_W    = 8,
    parameter int N_BANKS  = 2,
    parameter int N_IRQ    = 8,
    parameter int ADDR_W   = 8,
    parameter bit ACK_ONES = 1'b1,
    parameter logic [N_BANKS*REG_W-1:0] DIR_MASK = '1,
    parameter logic [N_BANKS*REG_W-1:0] OUT_INIT = '0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        host_addr,
    input  logic [BUS_W-1:0]         host_wdata,
    input  logic                     host_we,
    input  logic                     host_re,
    output logic [BUS_W-1:0]         host_rdata,
    output logic                     host_rvalid,
    input  logic [N_BANKS*REG_W-1:0] pin_in,
    output logic [N_BANKS*REG_W-1:0] pin_out,
    output logic [N_BANKS*REG_W-1:0] pin_oe,
    output logic                     irq_out
);

    localparam int NPINS = N_BANKS * REG_W;

    host_req_t        req_q;
    logic [NPINS-1:0] pins_sync;
    logic [N_IRQ-1:0] pending;
    logic             status_wr;
    logic [REG_W-1:0] status_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q.wr    <= host_we;
            req_q.rd    <= host_re;
            req_q.addr  <= GPX_ADDR_MAX'(host_addr);
            req_q.wdata <= GPX_DATA_MAX'(host_wdata);
        end
    end

    gpx_sync #(.W(NPINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    gpx_irq #(
        .N_IRQ    (N_IRQ),
        .REG_W    (REG_W),
        .ACK_ONES (ACK_ONES)
    ) u_irq (
        .clk          (clk),
        .rst          (rst),
        .src_sync     (pins_sync[N_IRQ-1:0]),
        .status_wr    (status_wr),
        .status_wdata (status_wdata),
        .pending      (pending),
        .irq_out      (irq_out)
    );

    gpx_regs #(
        .BUS_W    (BUS_W),
        .REG_W    (REG_W),
        .N_BANKS  (N_BANKS),
        .N_IRQ    (N_IRQ),
        .DIR_MASK (DIR_MASK),
        .OUT_INIT (OUT_INIT)
    ) u_regs (
        .clk          (clk),
        .rst          (rst),
        .req          (req_q),
        .pins_sync    (pins_sync),
        .pending      (pending),
        .latch        (pin_out),
        .rdata        (host_rdata),
        .rvalid       (host_rvalid),
        .status_wr    (status_wr),
        .status_wdata (status_wdata)
    );

    assign pin_oe = DIR_MASK;

endmodule

// File: tb/tb_gpx_expander.sv
module tb_gpx_expander;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] A_DIR  = 16'h0FF0;
    localparam logic [15:0] A_INIT = 16'h5A3C;
    localparam logic [15:0] B_DIR  = 16'hFF00;
    localparam logic [15:0] B_INIT = 16'h1234;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // configuration A: 16-bit bus, 8-bit registers, ack by ones
    logic [7:0]  a_addr = '0;
    logic [15:0] a_wd = '0;
    logic        a_we = 1'b0, a_re = 1'b0;
    logic [15:0] a_rd;
    logic        a_rv;
    logic [15:0] a_pin = '0;
    logic [15:0] a_out, a_oe;
    logic        a_irq;

    gpx_expander #(
        .BUS_W(16), .REG_W(8), .N_BANKS(2), .N_IRQ(8), .ADDR_W(8),
        .ACK_ONES(1'b1), .DIR_MASK(A_DIR), .OUT_INIT(A_INIT)
    ) dut (
        .clk(clk), .rst(rst), .host_addr(a_addr), .host_wdata(a_wd),
        .host_we(a_we), .host_re(a_re), .host_rdata(a_rd), .host_rvalid(a_rv),
        .pin_in(a_pin), .pin_out(a_out), .pin_oe(a_oe), .irq_out(a_irq)
    );

    // configuration B: 32-bit bus, 16-bit registers, ack by zeros
    logic [7:0]  b_addr = '0;
    logic [31:0] b_wd = '0;
    logic        b_we = 1'b0, b_re = 1'b0;
    logic [31:0] b_rd;
    logic        b_rv;
    logic [15:0] b_pin = '0;
    logic [15:0] b_out, b_oe;
    logic        b_irq;

    gpx_expander #(
        .BUS_W(32), .REG_W(16), .N_BANKS(1), .N_IRQ(4), .ADDR_W(8),
        .ACK_ONES(1'b0), .DIR_MASK(B_DIR), .OUT_INIT(B_INIT)
    ) dut_b (
        .clk(clk), .rst(rst), .host_addr(b_addr), .host_wdata(b_wd),
        .host_we(b_we), .host_re(b_re), .host_rdata(b_rd), .host_rvalid(b_rv),
        .pin_in(b_pin), .pin_out(b_out), .pin_oe(b_oe), .irq_out(b_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_a(input logic [7:0] addr, input logic [15:0] d);
        @(negedge clk); a_addr = addr; a_wd = d; a_we = 1'b1;
        @(negedge clk); a_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_a(input logic [7:0] addr, output logic [15:0] v, output logic vld);
        @(negedge clk); a_addr = addr; a_re = 1'b1;
        @(negedge clk); a_re = 1'b0;
        @(negedge clk); v = a_rd; vld = a_rv;
    endtask

    task automatic wr_b(input logic [7:0] addr, input logic [31:0] d);
        @(negedge clk); b_addr = addr; b_wd = d; b_we = 1'b1;
        @(negedge clk); b_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_b(input logic [7:0] addr, output logic [31:0] v);
        @(negedge clk); b_addr = addr; b_re = 1'b1;
        @(negedge clk); b_re = 1'b0;
        @(negedge clk); v = b_rd;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic        vld;
        logic [31:0] vb;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R5 reset state
        chk("R5 latch A", 32'(a_out), 32'(A_INIT));
        chk("R4 oe A", 32'(a_oe), 32'(A_DIR));
        chk("R5 irq A", 32'(a_irq), 0);
        chk("R5 rdata A", 32'(a_rd), 0);
        chk("R5 rvalid A", 32'(a_rv), 0);
        chk("R5 latch B", 32'(b_out), 32'(B_INIT));
        rd_a(8'h04, v, vld);
        chk("R5 no pending", 32'(v), 0);
        chk("R6 rvalid", 32'(vld), 1);

        // R2/R3/R4 pin map sweep over every pin
        a_pin = 16'hA000;
        for (int g = 0; g < 16; g++) begin
            logic [15:0] exp_out;
            logic [15:0] exp_view;
            exp_out  = 16'(1) << g;
            exp_view = (exp_out & A_DIR) | (a_pin & ~A_DIR);
            wr_a(8'((g / 8) << 1), 16'(1) << (g % 8));
            wr_a(8'((1 - g / 8) << 1), 16'h0000);
            chk($sformatf("R2 R4 pin_out g=%0d", g), 32'(a_out), 32'(exp_out));
            rd_a(8'((g / 8) << 1), v, vld);
            chk($sformatf("R3 bank read g=%0d", g), 32'(v),
                32'((exp_view >> (8 * (g / 8))) & 16'h00FF));
        end

        // R1 misaligned and out-of-range addresses
        wr_a(8'h00, 16'h00C3);
        wr_a(8'h02, 16'h0096);
        wr_a(8'h01, 16'h00FF);
        wr_a(8'h06, 16'h00FF);
        chk("R1 ignored writes", 32'(a_out), 32'h96C3);
        rd_a(8'h03, v, vld);
        chk("R1 misaligned read", 32'(v), 0);
        rd_a(8'h06, v, vld);
        chk("R1 range read", 32'(v), 0);
        a_pin = 16'h0000;
        repeat (3) @(negedge clk);

        // R7/R8/R10 per-source sweep
        for (int i = 0; i < 8; i++) begin
            a_pin = 16'(1) << i;
            @(negedge clk); @(negedge clk);
            chk($sformatf("R7 early irq i=%0d", i), 32'(a_irq), 0);
            @(negedge clk);
            chk($sformatf("R10 irq rise i=%0d", i), 32'(a_irq), 1);
            rd_a(8'h04, v, vld);
            chk($sformatf("R7 status i=%0d", i), 32'(v), 32'(1) << i);
            a_pin = 16'h0000;
            repeat (3) @(negedge clk);
            rd_a(8'h04, v, vld);
            chk($sformatf("R7 fall ignored i=%0d", i), 32'(v), 32'(1) << i);
            wr_a(8'h04, 16'h007F);
            rd_a(8'h04, v, vld);
            chk($sformatf("R8 wrong pattern i=%0d", i), 32'(v), 32'(1) << i);
            chk($sformatf("R10 irq held i=%0d", i), 32'(a_irq), 1);
            wr_a(8'h04, 16'h00FF);
            chk($sformatf("R8 irq cleared i=%0d", i), 32'(a_irq), 0);
            rd_a(8'h04, v, vld);
            chk($sformatf("R8 status cleared i=%0d", i), 32'(v), 0);
        end

        // R7 several sources together
        a_pin = 16'h0081;
        repeat (3) @(negedge clk);
        rd_a(8'h04, v, vld);
        chk("R7 multi", 32'(v), 32'h81);

        // R9/R11 edge on the acknowledge edge
        @(negedge clk); a_pin = 16'h0083;
        @(negedge clk); a_addr = 8'h04; a_wd = 16'h00FF; a_we = 1'b1;
        @(negedge clk); a_we = 1'b0;
        @(negedge clk);
        chk("R11 drop after ack", 32'(a_irq), 0);
        @(negedge clk);
        chk("R11 fresh rise", 32'(a_irq), 1);
        rd_a(8'h04, v, vld);
        chk("R9 edge kept", 32'(v), 32'h02);

        // configuration B: lane shift 2, zero acknowledge
        wr_b(8'h00, 32'h0000BEEF);
        chk("R4 B write", 32'(b_out), 32'hBEEF);
        chk("R4 B oe", 32'(b_oe), 32'(B_DIR));
        wr_b(8'h02, 32'h00000000);
        chk("R1 B misaligned", 32'(b_out), 32'hBEEF);
        b_pin = 16'h00C5;
        repeat (3) @(negedge clk);
        rd_b(8'h00, vb);
        chk("R3 B bank", vb, 32'h0000BEC5);
        rd_b(8'h04, vb);
        chk("R7 B status", vb, 32'h5);
        chk("R10 B irq", 32'(b_irq), 1);
        wr_b(8'h04, 32'h0000FFFF);
        rd_b(8'h04, vb);
        chk("R8 B ones ignored", vb, 32'h5);
        wr_b(8'h04, 32'h00000000);
        chk("R8 B irq cleared", 32'(b_irq), 0);
        rd_b(8'h04, vb);
        chk("R8 B zero ack", vb, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule